// File: doc/BRIEF.md
# SMI Feature Handshake and APM Trigger

This block runs a one-time feature agreement between platform firmware and the host, and turns writes to the power-management command port into system-management interrupts or ACPI mode changes. The host side presents a fixed mask of the features it supports. Firmware first stores the mask it wants, then writes a confirmation strobe. The block checks the stored request against the supported mask and against the dependencies between features. If the request is valid, the block copies it into the agreed set and locks it until reset.

Every write to the command port is classified. The two ACPI command codes each produce a one-cycle strobe toward the ACPI register block. Any other code produces an SMI, but only while the command-port enable bit of the SMI enable register is set. That SMI goes to every CPU when broadcast was agreed. Otherwise it goes only to the CPU that made the write.

Top module: `smi_apm_negotiator`

## Requirements
- R1: Reset clears the stored request, the agreed flag and the agreed mask, and holds every pulse output low.
- R2: A request write stores its 64-bit data. The value shows on the request readback one cycle later.
- R3: A confirmation strobe leaves the agreed flag at 0 when the stored request has any bit that the supported mask lacks.
- R4: A request that has bit 1 (CPU hotplug) or bit 2 (CPU hot-unplug) set while bit 0 (broadcast) is clear is rejected.
- R5: A request with bit 2 set and bit 1 clear is rejected. The configuration-error output is high whenever the supported mask has bit 2 set and bit 1 clear.
- R6: A strobe on a valid stored request sets the agreed flag and copies that request into the agreed mask, one cycle after the strobe. The request that is checked is the one held before any request write in the same cycle.
- R7: Once the agreed flag is set, further strobes and request writes leave the agreed flag and agreed mask unchanged.
- R8: A command-port write of 8'hE1 pulses the ACPI-enable strobe, and a write of 8'h1E pulses the ACPI-disable strobe. Neither write raises an SMI.
- R9: Any other command-port write raises no SMI while bit 5 of the SMI enable register is clear.
- R10: With bit 5 set and broadcast not agreed, any other write raises SMI only on the vector bit indexed by the writer's CPU id.
- R11: With bit 5 set and broadcast (bit 0) in the agreed mask, any other write raises SMI on every CPU.
- R12: Every strobe and SMI output is a single-cycle pulse, asserted in the cycle after the write that causes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_feat | input | 64 | Features the host supports |
| cfg_err | output | 1 | Supported mask has hot-unplug without hotplug |
| req_wr | input | 1 | Write enable for the requested mask |
| req_data | input | 64 | Requested mask written by firmware |
| req_mask | output | 64 | Stored requested mask |
| ok_wr | input | 1 | Confirmation strobe |
| feat_ok | output | 1 | Agreement accepted and locked |
| neg_feat | output | 64 | Agreed feature mask |
| smi_en | input | 32 | SMI enable register value |
| apm_wr | input | 1 | Command-port write |
| apm_data | input | 8 | Command-port write data |
| apm_cpu | input | 2 | Id of the CPU making the write |
| acpi_en_pulse | output | 1 | ACPI enable strobe |
| acpi_dis_pulse | output | 1 | ACPI disable strobe |
| smi_pulse | output | 4 | Per-CPU SMI pulses |

## Verification
A lock that fails to hold shows on the agreed mask one cycle after a later strobe. A corrupted agreed mask first shows when a command-port write fans SMI out to the wrong set of CPUs. A bad dependency check shows one cycle after the strobe as an agreed flag with the wrong value. A bad command decode shows in the cycle after the write, as a wrong strobe or a stray SMI bit. The bench drives every rejection case before a valid request. It then checks broadcast and single-CPU delivery, and resets in the middle of the run to confirm that the lock is released.

// File: rtl/smi_neg_pkg.sv
package smi_neg_pkg;
  localparam int FEAT_W = 64;
  typedef logic [FEAT_W-1:0] feat_t;

  typedef enum logic [1:0] {
    APM_IDLE     = 2'd0,
    APM_ACPI_ON  = 2'd1,
    APM_ACPI_OFF = 2'd2,
    APM_SMI      = 2'd3
  } apm_act_e;

  // supported mask that advertises hot-unplug without hotplug
  function automatic logic support_conflict(feat_t sup, int hp, int hup);
    return sup[hup] & ~sup[hp];
  endfunction

  // request validity: subset of supported, hot features need broadcast,
  // hot-unplug needs hotplug
  function automatic logic request_ok(feat_t req, feat_t sup, int bc, int hp, int hup);
    logic outside;
    logic hot_any;
    outside = |(req & ~sup);
    hot_any = req[hp] | req[hup];
    if (outside) return 1'b0;
    if (hot_any && !req[bc]) return 1'b0;
    if (req[hup] && !req[hp]) return 1'b0;
    return 1'b1;
  endfunction

  function automatic apm_act_e apm_classify(logic [7:0] code, logic [7:0] on_code,
                                            logic [7:0] off_code, logic smi_allowed);
    if (code == on_code) return APM_ACPI_ON;
    if (code == off_code) return APM_ACPI_OFF;
    if (smi_allowed) return APM_SMI;
    return APM_IDLE;
  endfunction
endpackage

// File: rtl/smi_feat_handshake.sv
module smi_feat_handshake #(
  parameter int BIT_BC  = 0,
  parameter int BIT_HP  = 1,
  parameter int BIT_HUP = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  smi_neg_pkg::feat_t   host_feat,
  input  logic                 req_wr,
  input  smi_neg_pkg::feat_t   req_data,
  input  logic                 ok_wr,
  output smi_neg_pkg::feat_t   req_mask,
  output logic                 feat_ok,
  output smi_neg_pkg::feat_t   neg_feat,
  output logic                 cfg_err,
  output logic                 accept_evt
);
  smi_neg_pkg::feat_t req_q;
  smi_neg_pkg::feat_t neg_q;
  logic               ok_q;
  logic               req_valid;

  assign req_valid  = smi_neg_pkg::request_ok(req_q, host_feat, BIT_BC, BIT_HP, BIT_HUP);
  assign accept_evt = ok_wr && !ok_q && req_valid;
  assign cfg_err    = smi_neg_pkg::support_conflict(host_feat, BIT_HP, BIT_HUP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q <= '0;
    end else if (req_wr) begin
      req_q <= req_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ok_q  <= 1'b0;
      neg_q <= '0;
    end else if (accept_evt) begin
      ok_q  <= 1'b1;
      neg_q <= req_q;
    end
  end

  assign req_mask = req_q;
  assign feat_ok  = ok_q;
  assign neg_feat = neg_q;
endmodule

// File: rtl/smi_apm_trigger.sv
module smi_apm_trigger #(
  parameter int         NCPU     = 4,
  parameter int         CPU_ID_W = 2,
  parameter int         SMIEN_W  = 32,
  parameter int         APMC_BIT = 5,
  parameter logic [7:0] CMD_ON   = 8'hE1,
  parameter logic [7:0] CMD_OFF  = 8'h1E
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                apm_wr,
  input  logic [7:0]          apm_data,
  input  logic [CPU_ID_W-1:0] apm_cpu,
  input  logic [SMIEN_W-1:0]  smi_en,
  input  logic                bcast,
  output logic                acpi_en_pulse,
  output logic                acpi_dis_pulse,
  output logic [NCPU-1:0]     smi_pulse,
  output logic                smi_fire
);
  smi_neg_pkg::apm_act_e act;
  logic                  on_q;
  logic                  off_q;

  always_comb begin
    act = smi_neg_pkg::APM_IDLE;
    if (apm_wr) begin
      act = smi_neg_pkg::apm_classify(apm_data, CMD_ON, CMD_OFF, smi_en[APMC_BIT]);
    end
  end

  assign smi_fire = (act == smi_neg_pkg::APM_SMI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      on_q  <= 1'b0;
      off_q <= 1'b0;
    end else begin
      on_q  <= (act == smi_neg_pkg::APM_ACPI_ON);
      off_q <= (act == smi_neg_pkg::APM_ACPI_OFF);
    end
  end

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    logic hit_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        hit_q <= 1'b0;
      end else begin
        hit_q <= smi_fire && (bcast || (apm_cpu == CPU_ID_W'(c)));
      end
    end
    assign smi_pulse[c] = hit_q;
  end

  assign acpi_en_pulse  = on_q;
  assign acpi_dis_pulse = off_q;
endmodule

// File: rtl/smi_apm_negotiator.sv
module smi_apm_negotiator #(
  parameter int         NCPU     = 4,
  parameter int         CPU_ID_W = (NCPU > 1) ? $clog2(NCPU) : 1,
  parameter int         SMIEN_W  = 32,
  parameter int         APMC_BIT = 5,
  parameter int         BIT_BC   = 0,
  parameter int         BIT_HP   = 1,
  parameter int         BIT_HUP  = 2,
  parameter logic [7:0] CMD_ON   = 8'hE1,
  parameter logic [7:0] CMD_OFF  = 8'h1E
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [63:0]         host_feat,
  output logic                cfg_err,
  input  logic                req_wr,
  input  logic [63:0]         req_data,
  output logic [63:0]         req_mask,
  input  logic                ok_wr,
  output logic                feat_ok,
  output logic [63:0]         neg_feat,
  input  logic [SMIEN_W-1:0]  smi_en,
  input  logic                apm_wr,
  input  logic [7:0]          apm_data,
  input  logic [CPU_ID_W-1:0] apm_cpu,
  output logic                acpi_en_pulse,
  output logic                acpi_dis_pulse,
  output logic [NCPU-1:0]     smi_pulse
);
  logic accept_evt;
  logic smi_fire;

  smi_feat_handshake #(
    .BIT_BC (BIT_BC),
    .BIT_HP (BIT_HP),
    .BIT_HUP(BIT_HUP)
  ) u_hs (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_feat (host_feat),
    .req_wr    (req_wr),
    .req_data  (req_data),
    .ok_wr     (ok_wr),
    .req_mask  (req_mask),
    .feat_ok   (feat_ok),
    .neg_feat  (neg_feat),
    .cfg_err   (cfg_err),
    .accept_evt(accept_evt)
  );

  smi_apm_trigger #(
    .NCPU    (NCPU),
    .CPU_ID_W(CPU_ID_W),
    .SMIEN_W (SMIEN_W),
    .APMC_BIT(APMC_BIT),
    .CMD_ON  (CMD_ON),
    .CMD_OFF (CMD_OFF)
  ) u_apm (
    .clk           (clk),
    .rst_n         (rst_n),
    .apm_wr        (apm_wr),
    .apm_data      (apm_data),
    .apm_cpu       (apm_cpu),
    .smi_en        (smi_en),
    .bcast         (neg_feat[BIT_BC]),
    .acpi_en_pulse (acpi_en_pulse),
    .acpi_dis_pulse(acpi_dis_pulse),
    .smi_pulse     (smi_pulse),
    .smi_fire      (smi_fire)
  );
endmodule

// File: rtl/smi_apm_negotiator_chk.sv
module smi_apm_negotiator_chk #(
  parameter int NCPU    = 4,
  parameter int BIT_BC  = 0,
  parameter int BIT_HP  = 1,
  parameter int BIT_HUP = 2
) (
  input logic            clk,
  input logic            rst_n,
  input logic [63:0]     host_feat,
  input logic            feat_ok,
  input logic [63:0]     neg_feat,
  input logic            apm_wr,
  input logic            acpi_en_pulse,
  input logic            acpi_dis_pulse,
  input logic [NCPU-1:0] smi_pulse,
  input logic            accept_evt,
  input logic            smi_fire
);
  AST_LOCK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    feat_ok |=> (feat_ok && $stable(neg_feat))); // R7

  AST_AGREED_SUBSET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(feat_ok) |-> ((neg_feat & ~host_feat) == 64'd0)); // R3

  AST_HOT_NEEDS_BCAST: assert property (@(posedge clk) disable iff (!rst_n)
    (feat_ok && (neg_feat[BIT_HP] || neg_feat[BIT_HUP])) |-> neg_feat[BIT_BC]); // R4

  AST_UNPLUG_NEEDS_PLUG: assert property (@(posedge clk) disable iff (!rst_n)
    feat_ok |-> !(neg_feat[BIT_HUP] && !neg_feat[BIT_HP])); // R5

  AST_ACCEPT_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |-> !feat_ok); // R7

  AST_ACPI_NO_SMI: assert property (@(posedge clk) disable iff (!rst_n)
    (acpi_en_pulse || acpi_dis_pulse) |-> (smi_pulse == '0)); // R8

  AST_SINGLE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    ((smi_pulse != '0) && !neg_feat[BIT_BC]) |-> $onehot(smi_pulse)); // R10

  AST_ALL_TARGETS: assert property (@(posedge clk) disable iff (!rst_n)
    (smi_fire && neg_feat[BIT_BC]) |=> (smi_pulse == {NCPU{1'b1}})); // R11

  AST_PULSE_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    ((smi_pulse != '0) || acpi_en_pulse || acpi_dis_pulse) |-> $past(apm_wr)); // R12
endmodule

bind smi_apm_negotiator smi_apm_negotiator_chk #(
  .NCPU   (NCPU),
  .BIT_BC (BIT_BC),
  .BIT_HP (BIT_HP),
  .BIT_HUP(BIT_HUP)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .host_feat     (host_feat),
  .feat_ok       (feat_ok),
  .neg_feat      (neg_feat),
  .apm_wr        (apm_wr),
  .acpi_en_pulse (acpi_en_pulse),
  .acpi_dis_pulse(acpi_dis_pulse),
  .smi_pulse     (smi_pulse),
  .accept_evt    (accept_evt),
  .smi_fire      (smi_fire)
);

// File: tb/test_smi_apm_negotiator.sv
module test_smi_apm_negotiator;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] host_feat = 64'h7;
  logic        req_wr = 1'b0;
  logic [63:0] req_data = '0;
  logic        ok_wr = 1'b0;
  logic [31:0] smi_en = '0;
  logic        apm_wr = 1'b0;
  logic [7:0]  apm_data = '0;
  logic [1:0]  apm_cpu = '0;
  logic        cfg_err, feat_ok, acpi_en_pulse, acpi_dis_pulse;
  logic [63:0] req_mask, neg_feat;
  logic [3:0]  smi_pulse;

  int n_checks = 0;
  int n_fail = 0;
  bit cmp_on = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  smi_apm_negotiator i_smi_apm_negotiator (
    .clk(clk), .rst_n(rst_n), .host_feat(host_feat), .cfg_err(cfg_err),
    .req_wr(req_wr), .req_data(req_data), .req_mask(req_mask),
    .ok_wr(ok_wr), .feat_ok(feat_ok), .neg_feat(neg_feat),
    .smi_en(smi_en), .apm_wr(apm_wr), .apm_data(apm_data), .apm_cpu(apm_cpu),
    .acpi_en_pulse(acpi_en_pulse), .acpi_dis_pulse(acpi_dis_pulse),
    .smi_pulse(smi_pulse)
  );

  // behavioural reference model
  logic [63:0] m_req, m_neg;
  logic        m_ok, m_on, m_off;
  logic [3:0]  m_smi;

  function automatic bit m_accepts(logic [63:0] r, logic [63:0] s);
    for (int b = 0; b < 64; b++) if (r[b] && !s[b]) return 1'b0;
    if (r[2]) begin
      if (!r[1]) return 1'b0;
      if (!r[0]) return 1'b0;
    end
    if (r[1] && !r[0]) return 1'b0;
    return 1'b1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_req <= '0; m_neg <= '0; m_ok <= 1'b0;
      m_on <= 1'b0; m_off <= 1'b0; m_smi <= '0;
    end else begin
      m_on <= 1'b0; m_off <= 1'b0; m_smi <= '0;
      if (ok_wr && !m_ok && m_accepts(m_req, host_feat)) begin
        m_ok  <= 1'b1;
        m_neg <= m_req;
      end
      if (req_wr) m_req <= req_data;
      if (apm_wr) begin
        if (apm_data == 8'hE1) m_on <= 1'b1;
        else if (apm_data == 8'h1E) m_off <= 1'b1;
        else if (smi_en[5]) m_smi <= m_neg[0] ? 4'hF : (4'h1 << apm_cpu);
      end
    end
  end

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h @%0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (cmp_on) begin
      check("R2 req_mask", req_mask, m_req);
      check("R6 feat_ok", {63'd0, feat_ok}, {63'd0, m_ok});
      check("R6 neg_feat", neg_feat, m_neg);
      check("R8 acpi strobes", {62'd0, acpi_en_pulse, acpi_dis_pulse}, {62'd0, m_on, m_off});
      check("R10 smi_pulse", {60'd0, smi_pulse}, {60'd0, m_smi});
      check("R5 cfg_err", {63'd0, cfg_err}, {63'd0, host_feat[2] & ~host_feat[1]});
    end
  end

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_req(logic [63:0] v);
    @(negedge clk); req_wr = 1'b1; req_data = v;
    @(negedge clk); req_wr = 1'b0;
  endtask

  task automatic strobe();
    @(negedge clk); ok_wr = 1'b1;
    @(negedge clk); ok_wr = 1'b0;
  endtask

  task automatic apm(logic [7:0] d, logic [1:0] cpu);
    @(negedge clk); apm_wr = 1'b1; apm_data = d; apm_cpu = cpu;
    @(negedge clk); apm_wr = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    // R1 reset state
    check("R1 req after reset", req_mask, 64'd0);
    check("R1 ok after reset", {63'd0, feat_ok}, 64'd0);
    check("R1 pulses after reset", {59'd0, smi_pulse, acpi_en_pulse}, 64'd0);
    // R3 unsupported bit
    write_req(64'h9);
    check("R2 readback", req_mask, 64'h9);
    strobe();
    check("R3 unsupported rejected", {63'd0, feat_ok}, 64'd0);
    // R4 hotplug without broadcast
    write_req(64'h2); strobe();
    check("R4 hotplug w/o bcast", {63'd0, feat_ok}, 64'd0);
    write_req(64'h6); strobe();
    check("R4 both hot w/o bcast", {63'd0, feat_ok}, 64'd0);
    // R5 unplug without plug
    write_req(64'h5); strobe();
    check("R5 unplug w/o plug", {63'd0, feat_ok}, 64'd0);
    // R9 no SMI when enable bit clear
    apm(8'h42, 2'd2);
    check("R9 smi masked", {60'd0, smi_pulse}, 64'd0);
    // R10 single CPU
    smi_en = 32'h20;
    apm(8'h42, 2'd2);
    check("R10 single target", {60'd0, smi_pulse}, 64'h4);
    @(negedge clk);
    check("R12 smi one cycle", {60'd0, smi_pulse}, 64'd0);
    // R8 ACPI commands
    apm(8'hE1, 2'd1);
    check("R8 enable strobe", {62'd0, acpi_en_pulse, acpi_dis_pulse}, 64'h2);
    check("R8 no smi on enable", {60'd0, smi_pulse}, 64'd0);
    apm(8'h1E, 2'd1);
    check("R8 disable strobe", {62'd0, acpi_en_pulse, acpi_dis_pulse}, 64'h1);
    @(negedge clk);
    check("R12 strobe one cycle", {62'd0, acpi_en_pulse, acpi_dis_pulse}, 64'd0);
    // R6 valid accept, request write in same cycle as strobe
    write_req(64'h3);
    @(negedge clk); ok_wr = 1'b1; req_wr = 1'b1; req_data = 64'h0;
    @(negedge clk); ok_wr = 1'b0; req_wr = 1'b0;
    check("R6 accepted", {63'd0, feat_ok}, 64'd1);
    check("R6 agreed value", neg_feat, 64'h3);
    // R7 lock
    write_req(64'h1); strobe();
    check("R7 locked mask", neg_feat, 64'h3);
    check("R7 still ok", {63'd0, feat_ok}, 64'd1);
    // R11 broadcast
    apm(8'h55, 2'd1);
    check("R11 broadcast", {60'd0, smi_pulse}, 64'hF);
    // R1 reset releases lock
    do_reset();
    check("R1 req cleared", req_mask, 64'd0);
    check("R1 ok cleared", {63'd0, feat_ok}, 64'd0);
    check("R1 neg cleared", neg_feat, 64'd0);
    // R5 config error
    host_feat = 64'h4; @(negedge clk);
    check("R5 cfg_err set", {63'd0, cfg_err}, 64'd1);
    host_feat = 64'h7; @(negedge clk);
    check("R5 cfg_err clear", {63'd0, cfg_err}, 64'd0);
    // non-broadcast agreement then per-CPU SMI
    write_req(64'h0); strobe();
    check("R6 empty accepted", {63'd0, feat_ok}, 64'd1);
    apm(8'h10, 2'd3);
    check("R10 cpu3 only", {60'd0, smi_pulse}, 64'h8);
    apm(8'h10, 2'd0);
    check("R10 cpu0 only", {60'd0, smi_pulse}, 64'h1);
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule